// File: doc/BRIEF.md
# Programmable AND, Fixed OR Logic Array

This block is a small field-configurable sum-of-products core. Eight inputs are offered, each in true and in inverted form, to a programmable AND plane that forms twenty product terms. A fixed OR plane then gathers those terms into four outputs. Each output owns five product terms, and no term is shared with another output. Only the AND plane holds configuration. The OR wiring never changes.

The configuration is loaded through a parallel address/data port. One write loads the full literal-select row of one product term. One further address loads a control word. For each output, that word sets an inversion bit (AND/NOR form) and a merge bit. The merge bit lets an output borrow the raw sum of its neighbour, so that a function needing more than five terms can spread across two groups. The configuration sits in registers, while the array path from inputs to outputs is purely combinational. A separate commit strobe marks the configuration as complete. Outputs are held at zero and flagged invalid until that commit, and again after any later write.

Top module: `pal_array`

## Requirements
- R1: After reset, out_valid is 0, data_out is 0, every fuse row is clear and the control word is clear.
- R2: Product term t includes input i uncomplemented when row bit 2i is set and complemented when row bit 2i+1 is set. The term is the AND of all included literals.
- R3: A product term whose row has no bit set evaluates to 0.
- R4: A product term that includes both an input and its complement evaluates to 0 for every input value.
- R5: The raw sum of output k is the OR of product terms 5k to 5k+4 only. A term never drives any other output.
- R6: Control bit k (for k < 4) inverts output k after the OR, which gives AND/NOR form.
- R7: Control bit 4+k makes output k use the OR of its own raw sum and the raw sum of output (k+1) mod 4, before inversion.
- R8: A write with cfg_addr below 20 loads that term's row. Address 20 loads the control word. Writes to addresses 21 to 31 change no row and no control bit.
- R9: Any write clears out_valid from the next cycle on. A commit with no write in the same cycle sets it from the next cycle on. A write and a commit in the same cycle leave it clear. While out_valid is 0, data_out is 0.
- R10: With a valid configuration, data_out follows data_in within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Term index (0 to 19) or control word (20) |
| cfg_data | input | 16 | Row of literal selects, or control word |
| cfg_commit | input | 1 | Marks the configuration complete |
| data_in | input | 8 | Array inputs |
| data_out | output | 4 | Array outputs |
| out_valid | output | 1 | High while the configuration is committed |

## Verification
A configuration write and a commit can arrive in the same cycle, and the write must win, so the array stays invalid. The bench drives both strobes together on one edge. The cycle after, it expects out_valid low and data_out at zero. A lone commit then restores validity. A behavioural model tracks the fuses and the valid flag on every edge and is compared against both outputs on every cycle. The bench also sweeps all 256 input values after each commit.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        TGT_ROW  = 2'd0,
        TGT_CTRL = 2'd1,
        TGT_NONE = 2'd2
    } cfg_target_e;

    function automatic cfg_target_e classify_addr(input int unsigned addr,
                                                  input int unsigned n_terms);
        if (addr < n_terms)
            return TGT_ROW;
        else if (addr == n_terms)
            return TGT_CTRL;
        else
            return TGT_NONE;
    endfunction

endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
    parameter int N_IN    = 8,
    parameter int N_OUT   = 4,
    parameter int N_TERMS = 20,
    parameter int ADDR_W  = 5,
    localparam int ROW_W  = 2 * N_IN
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic [ROW_W-1:0]                cfg_data,
    input  logic                            cfg_commit,
    output logic [N_TERMS-1:0][ROW_W-1:0]   rows,
    output logic [N_OUT-1:0]                invert,
    output logic [N_OUT-1:0]                merge,
    output logic                            ready
);
    import pal_pkg::*;

    typedef struct packed {
        logic [N_TERMS-1:0][ROW_W-1:0] rows;
        logic [N_OUT-1:0]              invert;
        logic [N_OUT-1:0]              merge;
        logic                          done;
    } store_t;

    store_t      st_d, st_q;
    cfg_target_e tgt;

    always_comb begin
        st_d = st_q;
        tgt  = classify_addr(int'(cfg_addr), N_TERMS);
        if (cfg_we) begin
            unique case (tgt)
                TGT_ROW: st_d.rows[cfg_addr] = cfg_data;
                TGT_CTRL: begin
                    st_d.invert = cfg_data[N_OUT-1:0];
                    st_d.merge  = cfg_data[2*N_OUT-1:N_OUT];
                end
                default: ;
            endcase
            st_d.done = 1'b0;
        end else if (cfg_commit) begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rows   = st_q.rows;
    assign invert = st_q.invert;
    assign merge  = st_q.merge;
    assign ready  = st_q.done;

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
    parameter int N_IN    = 8,
    parameter int N_TERMS = 20,
    localparam int ROW_W  = 2 * N_IN
) (
    input  logic [N_IN-1:0]               in_vec,
    input  logic [N_TERMS-1:0][ROW_W-1:0] rows,
    output logic [N_TERMS-1:0]            terms
);
    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        logic [N_IN-1:0] lit_ok;
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            always_comb begin
                lit_ok[i] = (~rows[t][2*i]   |  in_vec[i]) &
                            (~rows[t][2*i+1] | ~in_vec[i]);
            end
        end
        always_comb terms[t] = (|rows[t]) & (&lit_ok);
    end
endmodule

// File: rtl/pal_or_plane.sv
module pal_or_plane #(
    parameter int N_OUT = 4,
    parameter int TPO   = 5,
    localparam int N_TERMS = N_OUT * TPO
) (
    input  logic [N_TERMS-1:0] terms,
    input  logic [N_OUT-1:0]   invert,
    input  logic [N_OUT-1:0]   merge,
    input  logic               ready,
    output logic [N_OUT-1:0]   out_vec
);
    logic [N_OUT-1:0] raw_sum;
    logic [N_OUT-1:0] joined;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam int PARTNER = (k + 1) % N_OUT;
        always_comb begin
            raw_sum[k] = |terms[k*TPO +: TPO];
        end
        always_comb begin
            joined[k]  = raw_sum[k] | (merge[k] & raw_sum[PARTNER]);
            out_vec[k] = ready & (joined[k] ^ invert[k]);
        end
    end
endmodule

// File: rtl/pal_array.sv
module pal_array #(
    parameter int N_IN   = 8,
    parameter int N_OUT  = 4,
    parameter int TPO    = 5,
    localparam int N_TERMS = N_OUT * TPO,
    localparam int ROW_W   = 2 * N_IN,
    localparam int ADDR_W  = $clog2(N_TERMS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ROW_W-1:0]  cfg_data,
    input  logic              cfg_commit,
    input  logic [N_IN-1:0]   data_in,
    output logic [N_OUT-1:0]  data_out,
    output logic              out_valid
);
    logic [N_TERMS-1:0][ROW_W-1:0] rows;
    logic [N_OUT-1:0]              invert;
    logic [N_OUT-1:0]              merge;
    logic                          ready;
    logic [N_TERMS-1:0]            terms;

    pal_fuse_store #(
        .N_IN(N_IN), .N_OUT(N_OUT), .N_TERMS(N_TERMS), .ADDR_W(ADDR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_commit(cfg_commit),
        .rows(rows), .invert(invert), .merge(merge), .ready(ready)
    );

    pal_and_plane #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_and (
        .in_vec(data_in), .rows(rows), .terms(terms)
    );

    pal_or_plane #(.N_OUT(N_OUT), .TPO(TPO)) u_or (
        .terms(terms), .invert(invert), .merge(merge), .ready(ready),
        .out_vec(data_out)
    );

    assign out_valid = ready;
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
    parameter int N_OUT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_commit,
    input logic [N_OUT-1:0] data_out,
    input logic             out_valid
);
    assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !out_valid)
        else $error("write did not clear valid");

    assert_commit_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_commit && !cfg_we) |=> out_valid)
        else $error("commit did not set valid");

    assert_valid_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !cfg_commit) |=> $stable(out_valid))
        else $error("valid changed with no strobe");

    assert_gated_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (data_out == '0))
        else $error("output active while invalid");

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid)
        else $error("valid set straight after reset");
endmodule

bind pal_array pal_array_chk #(.N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_commit(cfg_commit),
    .data_out(data_out), .out_valid(out_valid)
);

// File: tb/sim_pal_array.sv
module sim_pal_array;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 8;
    localparam int NO = 4;
    localparam int NT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic        cfg_commit = 1'b0;
    logic [7:0]  data_in = '0;
    logic [3:0]  data_out;
    logic        out_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model state
    int m_row [NT];
    int m_inv = 0;
    int m_mrg = 0;
    bit m_done = 0;

    pal_array u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_commit(cfg_commit), .data_in(data_in),
        .data_out(data_out), .out_valid(out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int model_eval(input int inp);
        int sums [NO];
        int res = 0;
        for (int k = 0; k < NO; k++) begin
            sums[k] = 0;
            for (int t = k*5; t < k*5+5; t++) begin
                bit hit = (m_row[t] != 0);
                for (int i = 0; i < NI; i++) begin
                    bit v = ((inp >> i) & 1) != 0;
                    if (((m_row[t] >> (2*i)) & 1) != 0 && !v) hit = 0;
                    if (((m_row[t] >> (2*i+1)) & 1) != 0 && v) hit = 0;
                end
                if (hit) sums[k] = 1;
            end
        end
        for (int k = 0; k < NO; k++) begin
            int s = sums[k];
            if (((m_mrg >> k) & 1) != 0 && sums[(k+1)%NO] != 0) s = 1;
            if (((m_inv >> k) & 1) != 0) s = 1 - s;
            res |= s << k;
        end
        return m_done ? res : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) m_row[t] = 0;
            m_inv = 0; m_mrg = 0; m_done = 0;
        end else if (cfg_we) begin
            if (cfg_addr < NT) m_row[cfg_addr] = int'(cfg_data);
            else if (cfg_addr == NT) begin
                m_inv = int'(cfg_data[3:0]);
                m_mrg = int'(cfg_data[7:4]);
            end
            m_done = 0;
        end else if (cfg_commit) begin
            m_done = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_cmp++;
            if (out_valid !== m_done) begin
                n_bad++;
                $display("FAIL R9 valid got %0b expected %0b", out_valid, m_done);
            end
            n_cmp++;
            if (int'(data_out) != model_eval(int'(data_in)) || $isunknown(data_out)) begin
                n_bad++;
                $display("FAIL R5 data_out got %h expected %h (in=%h)",
                         data_out, model_eval(int'(data_in)), data_in);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_data = 16'(d);
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic commit();
        cfg_commit = 1'b1;
        cyc();
        cfg_commit = 1'b0;
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic probe(input string tag, input int inp, input int exp);
        data_in = 8'(inp);
        #2;
        check(tag, int'(data_out), exp);
        cyc();
    endtask

    task automatic sweep();
        for (int v = 0; v < 256; v++) begin
            data_in = 8'(v);
            cyc();
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        check("R1 valid", int'(out_valid), 0);
        check("R1 data", int'(data_out), 0);
        commit();
        check("R1 cleared fuses", int'(data_out), 0);

        // R2 R3 R4 R5 R6 R8: load terms and control
        wr(0, 16'h0005);   // in0 & in1
        wr(1, 16'h0060);   // ~in2 & in3
        wr(5, 16'h4000);   // in7
        wr(6, 16'h0000);   // empty term
        wr(10, 16'h0300);  // in4 & ~in4
        wr(11, 16'h0800);  // ~in5
        wr(15, 16'h1001);  // in6 & in0
        wr(20, 16'h0008);  // invert output 3
        check("R9 invalid after write", int'(out_valid), 0);
        commit();
        check("R9 valid after commit", int'(out_valid), 1);
        probe("R2 and of literals", 8'h03, 4'hD);
        probe("R5 no leak to other output", 8'h80, 4'hE);
        probe("R4 contradictory term", 8'h30, 4'h8);
        probe("R6 inverted output", 8'h41, 4'h4);
        probe("R3 empty term", 8'h00, 4'hC);
        sweep();

        // R7: merge output 0 with output 1
        wr(20, 16'h0018);
        commit();
        probe("R7 merge with neighbour", 8'h80, 4'hF);
        probe("R7 merge idle", 8'h00, 4'hC);
        sweep();

        // R7: merge wraps from output 3 to output 0
        wr(20, 16'h0088);
        commit();
        probe("R7 wrap merge", 8'h03, 4'h5);
        sweep();

        // R8: out-of-range address has no effect on the array
        wr(21, 16'hFFFF);
        wr(31, 16'hFFFF);
        commit();
        probe("R8 ignored address", 8'h03, 4'h5);
        probe("R8 ignored address b", 8'h80, 4'hE);

        // R9: write and commit together
        cfg_we = 1'b1; cfg_addr = 5'd25; cfg_data = 16'h1234; cfg_commit = 1'b1;
        cyc();
        cfg_we = 1'b0; cfg_commit = 1'b0;
        check("R9 write beats commit", int'(out_valid), 0);
        check("R9 gated output", int'(data_out), 0);
        commit();
        check("R9 recommit", int'(out_valid), 1);

        // R10: combinational path
        data_in = 8'h03;
        #1;
        check("R10 same-cycle a", int'(data_out), 4'h5);
        data_in = 8'h41;
        #1;
        check("R10 same-cycle b", int'(data_out), 4'h4);
        cyc();
        sweep();
        cyc();
        summary();
    end
endmodule